// File: doc/BRIEF.md
# 3x3 Box Smoothing Filter for Streamed Grayscale Pixels

This block takes 8-bit grayscale pixels one at a time, in raster order, and produces a smoothed value for each interior image position. Each result is the total of the nine pixels in the 3x3 neighbourhood around a position. That total is divided by eight with a three-bit right shift, so the block needs no divider. Because nine pixels divided by eight can exceed the pixel range, the result is clamped to 255.

The two rows above the current row are kept in two single-port-style RAM line buffers, each one line long. Each buffer is indexed by the same wrapping column pointer. At every accepted pixel, a column is read and then rewritten with data one row newer, so no shift-register FIFO is needed. A 3x3 register window collects the three rows of the current column. A result is produced only once the window covers real pixels: row index at least 2 and column index at least 2. Each result belongs to the centre position (row-1, column-1). The line length is set by the parameter `LINE_W`. Rows are unbounded, so a new image is started by applying reset.

Top module: `box3_smoother`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `out_pix` is 0 until the first result is produced.
- R2: For the pixel accepted at row r, column c (both counted from 0 since reset, with r and c at least 2), the block outputs min(255, floor(S/8)). S is the sum of the pixels at rows r-2..r and columns c-2..c.
- R3: When floor(S/8) exceeds 255 (any S of 2048 or more, e.g. a region of uniform 230 or 255), the output is exactly 255.
- R4: No result is produced for pixels with column index 0 or 1, or with row index 0 or 1. Each full line from row 2 on yields exactly `LINE_W`-2 results.
- R5: A result leaves on the clock edge three rising edges after the edge that accepted its pixel, counting the accepting edge as the first. `out_valid` is high for exactly one cycle per result.
- R6: The column pointer counts 0 to `LINE_W`-1 on accepted pixels and then wraps to 0, and each wrap begins a new row.
- R7: In cycles with `in_valid` low, no pixel is taken and the pointer, row count, window and line buffers keep their values. A stream with idle gaps gives the same results as the same stream sent without gaps.
- R8: A reset in the middle of a line discards the pixels in flight and restarts counting at row 0, column 0. The first two rows after it produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel is offered on `in_pix` this cycle |
| in_pix | input | 8 | Incoming grayscale pixel, raster order |
| out_valid | output | 1 | `out_pix` holds a new smoothed result |
| out_pix | output | 8 | Smoothed, clamped pixel |

## Verification
The bench targets regions bright enough to overflow the divide-by-eight. A design without the clamp would wrap those results to small values near zero. Line wrap is exercised continuously, so an off-by-one pointer would produce results at the first two columns or misalign every line after the first. Random idle gaps check that pixels are not taken or the window is not shifted while `in_valid` is low; otherwise results would come from the wrong neighbours or arrive at the wrong cycle. A reset in the middle of a line checks that stale rows and in-flight results are dropped and that no result leaks out during the two rows after it.

// File: rtl/box3_pkg.sv
`timescale 1ns/1ps
package box3_pkg;
  parameter int unsigned PIX_W  = 8;
  parameter int unsigned KSIZE  = 3;
  parameter int unsigned SHIFT  = 3;

  localparam int unsigned NPIX    = KSIZE * KSIZE;
  localparam int unsigned SUM_W   = PIX_W + $clog2(NPIX);
  localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;
  localparam int unsigned WIN_W   = NPIX * PIX_W;
  localparam int unsigned COL_W   = KSIZE * PIX_W;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [SUM_W-1:0] sum_t;

  // total of all window pixels, packed as NPIX fields of PIX_W bits
  function automatic sum_t add_window(input logic [WIN_W-1:0] w);
    sum_t total;
    total = '0;
    for (int i = 0; i < int'(NPIX); i++) begin
      total = total + sum_t'(w[i*PIX_W +: PIX_W]);
    end
    return total;
  endfunction

  // shift scaling followed by clamp to the top pixel code
  function automatic pix_t scale_clamp(input sum_t s);
    sum_t q;
    q = s >> SHIFT;
    if (q > sum_t'(PIX_MAX)) begin
      return pix_t'(PIX_MAX);
    end
    return q[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/box3_line_ram.sv
`timescale 1ns/1ps
module box3_line_ram #(
  parameter int unsigned DEPTH  = 640,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // registered read; the write to the same column comes one cycle later
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/box3_scan_ctrl.sv
`timescale 1ns/1ps
module box3_scan_ctrl #(
  parameter int unsigned LINE_W = 640,
  parameter int unsigned ADDR_W = $clog2(LINE_W),
  parameter int unsigned KSIZE  = 3,
  parameter int unsigned ROW_W  = $clog2(KSIZE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [ADDR_W-1:0] col,
  output logic [ROW_W-1:0]  row,
  output logic              line_end,
  output logic              win_full
);
  localparam logic [ADDR_W-1:0] COL_LAST = ADDR_W'(LINE_W - 1);
  localparam logic [ADDR_W-1:0] COL_EDGE = ADDR_W'(KSIZE - 1);
  localparam logic [ROW_W-1:0]  ROW_TOP  = ROW_W'(KSIZE - 1);

  assign line_end = (col == COL_LAST);
  assign win_full = (row == ROW_TOP) && (col >= COL_EDGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (line_end) begin
        col <= '0;
        if (row != ROW_TOP) begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/box3_window.sv
`timescale 1ns/1ps
module box3_window
  import box3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [COL_W-1:0] col_in,
  output logic [WIN_W-1:0] win_flat
);
  // win[r][c]: r = 0 is the newest row, c = KSIZE-1 the newest column
  pix_t win [KSIZE][KSIZE];

  for (genvar r = 0; r < int'(KSIZE); r++) begin : g_row
    for (genvar c = 0; c < int'(KSIZE); c++) begin : g_col
      if (c == int'(KSIZE) - 1) begin : g_load
        always_ff @(posedge clk) begin
          if (rst) begin
            win[r][c] <= '0;
          end else if (shift_en) begin
            win[r][c] <= col_in[r*PIX_W +: PIX_W];
          end
        end
      end else begin : g_move
        always_ff @(posedge clk) begin
          if (rst) begin
            win[r][c] <= '0;
          end else if (shift_en) begin
            win[r][c] <= win[r][c+1];
          end
        end
      end
      assign win_flat[(r*KSIZE + c)*PIX_W +: PIX_W] = win[r][c];
    end
  end
endmodule

// File: rtl/box3_smoother.sv
`timescale 1ns/1ps
module box3_smoother
  import box3_pkg::*;
#(
  parameter int unsigned LINE_W = 640,
  parameter int unsigned ADDR_W = $clog2(LINE_W),
  parameter int unsigned ROW_W  = $clog2(KSIZE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  localparam int unsigned NTAP = KSIZE - 1;

  // named events for the checker
  logic              acc;
  logic [ADDR_W-1:0] col;
  logic [ROW_W-1:0]  row;
  logic              line_end;
  logic              win_full;
  logic              win_ready;
  sum_t              win_sum;

  assign acc = in_valid;

  box3_scan_ctrl #(
    .LINE_W (LINE_W),
    .ADDR_W (ADDR_W),
    .KSIZE  (KSIZE),
    .ROW_W  (ROW_W)
  ) u_scan (
    .clk      (clk),
    .rst      (rst),
    .adv      (acc),
    .col      (col),
    .row      (row),
    .line_end (line_end),
    .win_full (win_full)
  );

  // stage 1: pixel and position alongside the RAM read data
  logic              s1_valid;
  logic              s1_full;
  pix_t              s1_pix;
  logic [ADDR_W-1:0] s1_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_full  <= 1'b0;
      s1_pix   <= '0;
      s1_col   <= '0;
    end else begin
      s1_valid <= acc;
      s1_full  <= acc && win_full;
      if (acc) begin
        s1_pix <= in_pix;
        s1_col <= col;
      end
    end
  end

  pix_t             tap_q [NTAP];
  logic [COL_W-1:0] col_in;

  assign col_in[0 +: PIX_W] = s1_pix;

  for (genvar k = 0; k < int'(NTAP); k++) begin : g_tap
    pix_t wr_d;
    if (k == 0) begin : g_first
      assign wr_d = s1_pix;
    end else begin : g_next
      assign wr_d = tap_q[k-1];
    end

    box3_line_ram #(
      .DEPTH  (LINE_W),
      .ADDR_W (ADDR_W),
      .DATA_W (PIX_W)
    ) u_line (
      .clk     (clk),
      .rd_en   (acc),
      .rd_addr (col),
      .rd_data (tap_q[k]),
      .wr_en   (s1_valid),
      .wr_addr (s1_col),
      .wr_data (wr_d)
    );

    assign col_in[(k+1)*PIX_W +: PIX_W] = tap_q[k];
  end

  // stage 2: window registers
  logic [WIN_W-1:0] win_flat;

  box3_window u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (s1_valid),
    .col_in   (col_in),
    .win_flat (win_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_ready <= 1'b0;
    end else begin
      win_ready <= s1_valid && s1_full;
    end
  end

  assign win_sum = add_window(win_flat);

  // stage 3: scale, clamp, register out
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= win_ready;
      if (win_ready) begin
        out_pix <= scale_clamp(win_sum);
      end
    end
  end
endmodule

// File: rtl/box3_smoother_chk.sv
`timescale 1ns/1ps
module box3_smoother_chk
  import box3_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ROW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_valid,
  input  logic [PIX_W-1:0]  out_pix,
  input  logic [ADDR_W-1:0] col,
  input  logic [ROW_W-1:0]  row,
  input  logic              line_end,
  input  logic              win_ready,
  input  sum_t              win_sum
);
  localparam sum_t SAT_EDGE = sum_t'((PIX_MAX + 1) << SHIFT);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == '0));

  p_sat_r3: assert property (@(posedge clk) disable iff (rst)
    (win_ready && win_sum >= SAT_EDGE) |=> (out_valid && out_pix == PIX_W'(PIX_MAX)));

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));

  p_col_step_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !line_end) |=> (col == ADDR_W'($past(col) + 1'b1)));

  p_col_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && line_end) |=> (col == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(col) && $stable(row)));
endmodule

bind box3_smoother box3_smoother_chk #(
  .ADDR_W (ADDR_W),
  .ROW_W  (ROW_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_pix   (out_pix),
  .col       (col),
  .row       (row),
  .line_end  (line_end),
  .win_ready (win_ready),
  .win_sum   (win_sum)
);

// File: tb/box3_smoother_test.sv
`timescale 1ns/1ps
module box3_smoother_test;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  always #2 clk = ~clk;

  box3_smoother #(.LINE_W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    ncnt  = 0;
  int    hist[$];
  int    rowi = 0;
  int    coli = 0;
  int    exp_val[$];
  int    exp_due[$];
  string exp_tag[$];
  string cur_tag = "R2";
  int    seen_out = 0;
  int    want_out = 0;
  bit    done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: whole stream kept as rows of W pixels
  task automatic model_accept(int p);
    int s;
    int e;
    hist.push_back(p);
    if (rowi >= 2 && coli >= 2) begin
      s = 0;
      for (int dr = 0; dr < 3; dr++) begin
        for (int dc = 0; dc < 3; dc++) begin
          s += hist[(rowi - dr) * W + coli - dc];
        end
      end
      e = s / 8;
      exp_tag.push_back(e > 255 ? "R3" : cur_tag);
      exp_val.push_back(e > 255 ? 255 : e);
      exp_due.push_back(ncnt + 3);
      want_out++;
    end
    coli++;
    if (coli == W) begin
      coli = 0;
      rowi++;
    end
  endtask

  task automatic sample();
    if (out_valid) begin
      seen_out++;
      if (exp_due.size() != 0 && exp_due[0] == ncnt) begin
        check(exp_tag[0], int'(out_pix), exp_val[0]);
        void'(exp_val.pop_front());
        void'(exp_due.pop_front());
        void'(exp_tag.pop_front());
      end else begin
        check("R4 R5 unexpected out_valid", 1, 0);
      end
    end else if (exp_due.size() != 0 && exp_due[0] == ncnt) begin
      check("R5 missing out_valid", 0, 1);
      void'(exp_val.pop_front());
      void'(exp_due.pop_front());
      void'(exp_tag.pop_front());
    end
  endtask

  task automatic tick(bit v, int p, bit r);
    @(negedge clk);
    sample();
    rst = r;
    in_valid = v;
    in_pix = 8'(p);
    if (r) begin
      exp_val.delete();
      exp_due.delete();
      exp_tag.delete();
      hist.delete();
      want_out = seen_out;
      rowi = 0;
      coli = 0;
    end else if (v) begin
      model_accept(p);
    end
    ncnt++;
  endtask

  task automatic send_rows(int nrows, int kind, int gaps);
    for (int r = 0; r < nrows; r++) begin
      for (int c = 0; c < W; c++) begin
        int p;
        case (kind)
          0: p = (r * 37 + c * 19) & 255;
          1: p = 255;
          2: p = 230;
          3: p = int'($urandom_range(0, 255));
          default: p = 0;
        endcase
        if (gaps != 0) begin
          int g = int'($urandom_range(0, 2));
          for (int i = 0; i < g; i++) tick(0, 0, 0);
        end
        tick(1, p, 0);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick(0, 0, 1);
    tick(0, 0, 0);
    tick(0, 0, 0);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_pix after reset", int'(out_pix), 0);

    cur_tag = "R6";
    send_rows(5, 0, 0);
    cur_tag = "R2";
    send_rows(3, 1, 0);
    send_rows(3, 2, 0);
    send_rows(2, 4, 0);
    cur_tag = "R7";
    send_rows(5, 3, 1);
    cur_tag = "R2";
    send_rows(3, 3, 0);

    // reset in the middle of a line
    tick(1, 200, 0);
    tick(1, 201, 0);
    tick(1, 202, 0);
    tick(0, 0, 1);
    tick(0, 0, 1);
    cur_tag = "R8";
    send_rows(4, 3, 0);

    for (int i = 0; i < 8; i++) tick(0, 0, 0);
    check("R4 result count", seen_out, want_out);
    check("R5 no pending results", exp_due.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule